// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block is an 8-bit up-counter fed from one external input pin. It runs in one of two modes. In edge mode it adds one for each chosen transition on the pin. In gated mode it adds one on every cycle of an external tick enable while the pin sits at its active level, so it measures how long the pin stays active. Because software can load the counter, it can set the counter to a start value and get an interrupt after a chosen number of counts. The overflow interrupt comes when the counter wraps from 0xFF to 0x00.

The pin passes through a two-stage synchronizer before edges are detected. Two sticky flags record overflow and input transitions. Software clears each flag by writing a one to it. Each flag has an enable bit, and an interrupt is raised when a flag and its enable bit are both set. The tick enable comes from a prescaler outside this block. The register port is a plain select/write/read interface with no handshake.

Top module: `pulse_accum`

## Requirements
- R1: After reset the counter, the control register and both flags read 0, and `irq` is 0.
- R2: Register select 0 is control, 1 is the counter, 2 is status, and 3 reads 0 and ignores writes. A counter write stores the data on the next clock edge. If a count is due on the same cycle, the write wins: the count is dropped and no overflow is set.
- R3: Control bit 0 enables counting. Control bit 1 picks the mode, with 0 meaning edge mode. Control bit 2 is the polarity. In edge mode, polarity 0 counts rising edges and polarity 1 counts falling edges, and the opposite edge is not counted. The counter shows a pin change on the third rising clock edge after that change.
- R4: In gated mode the counter adds one on each clock where `tickEn` is 1 and the synchronized pin is at its active level. The active level is high for polarity 0 and low for polarity 1. With `tickEn` low, or with the pin at its inactive level, the counter holds.
- R5: A count that takes the counter from 0xFF to 0x00 sets the overflow flag, which is status bit 0.
- R6: The edge flag is status bit 1. In edge mode each counted edge sets it. In gated mode it is set when the gate goes inactive, and the edge where the gate becomes active leaves it unchanged.
- R7: Writing status clears each flag whose data bit is 1 and leaves the others unchanged. If a flag is set on the same cycle that it is cleared, it stays set.
- R8: `irq` is 1 exactly when the overflow flag is set together with control bit 3, or the edge flag is set together with control bit 4.
- R9: With control bit 0 clear, neither pin activity nor `tickEn` changes the counter or the flags.
- R10: In edge mode `tickEn` has no effect: edges are counted whatever its value, and ticks without edges add nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Divided time base used in gated mode |
| pinIn | input | 1 | External pulse input, asynchronous to the clock |
| regSel | input | 2 | Register select |
| regWr | input | 1 | Write strobe for the selected register |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the selected register, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `pinIn` is held at 0 while reset is active, so no edge comes from the synchronizer filling up. They also assume that the register port changes only between clock edges. The bench drives the pin, `tickEn` and every register access on the falling clock edge. It holds each pin level for at least four clocks, so every transition passes through the synchronizer before the next one arrives. The bench never changes the mode or polarity while the pin is active.

// File: rtl/pulse_accum_pkg.sv
package pulse_accum_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  // control register, bit 0 is enable
  typedef struct packed {
    logic edgeIrqEn;   // bit 4
    logic ovfIrqEn;    // bit 3
    logic polarity;    // bit 2
    logic gated;       // bit 1
    logic enable;      // bit 0
  } paCtrl_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic inc;
    logic setOvf;
    logic setEdge;
    logic wrCtrl;
    logic wrStatus;
  } paStrobe_t;

  localparam int CTRL_W = $bits(paCtrl_t);

endpackage

// File: rtl/pa_input_sync.sv
module pa_input_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic syncLevel,
  output logic riseSeen,
  output logic fallSeen
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] stage;
  logic prevLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= 1'b0;
    else       stage[0] <= pinIn;
  end

  generate
    for (genvar g = 1; g < SYNC_STAGES; g++) begin : gStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= 1'b0;
        else       stage[g] <= stage[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= 1'b0;
    else       prevLevel <= stage[LAST];
  end

  assign syncLevel = stage[LAST];
  assign riseSeen  = stage[LAST] & ~prevLevel;
  assign fallSeen  = ~stage[LAST] & prevLevel;

  // a detected rise reflects the pin value SYNC_STAGES clocks earlier
  assert_rise_tracks_pin_R3: assert property (@(posedge clk) disable iff (!rstN)
    riseSeen |-> $past(pinIn, SYNC_STAGES));

endmodule

// File: rtl/pa_control.sv
module pa_control
  import pulse_accum_pkg::*;
(
  input  paCtrl_t    ctrl,
  input  logic       regWr,
  input  logic [1:0] regSel,
  input  logic       syncLevel,
  input  logic       riseSeen,
  input  logic       fallSeen,
  input  logic       tickEn,
  input  logic       cntAtMax,
  output paStrobe_t  strobe
);

  logic activeEdge;
  logic trailingEdge;
  logic gateOn;
  logic countReq;

  always_comb begin
    activeEdge   = ctrl.polarity ? fallSeen : riseSeen;
    trailingEdge = ctrl.polarity ? riseSeen : fallSeen;
    gateOn       = syncLevel ^ ctrl.polarity;
    countReq     = ctrl.enable & (ctrl.gated ? (gateOn & tickEn) : activeEdge);

    strobe.wrCtrl   = regWr & (regSel == SEL_CTRL);
    strobe.wrStatus = regWr & (regSel == SEL_STATUS);
    strobe.load     = regWr & (regSel == SEL_COUNT);
    // a software write to the counter pre-empts a count
    strobe.inc      = countReq & ~strobe.load;
    strobe.setOvf   = strobe.inc & cntAtMax;
    strobe.setEdge  = ctrl.enable & (ctrl.gated ? trailingEdge : activeEdge);
  end

endmodule

// File: rtl/pa_datapath.sv
module pa_datapath
  import pulse_accum_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  paStrobe_t        strobe,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       regSel,
  output paCtrl_t          ctrlQ,
  output logic             cntAtMax,
  output logic [CNT_W-1:0] rdData,
  output logic             irq
);

  logic [CNT_W-1:0] countQ;
  logic             ovfFlag;
  logic             edgeFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ctrlQ <= '0;
    else if (strobe.wrCtrl) ctrlQ <= paCtrl_t'(wrData[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           countQ <= '0;
    else if (strobe.load) countQ <= wrData;
    else if (strobe.inc)  countQ <= countQ + 1'b1;
  end

  // sticky flags, write one to clear, a set wins over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag  <= 1'b0;
      edgeFlag <= 1'b0;
    end else begin
      ovfFlag  <= (ovfFlag  & ~(strobe.wrStatus & wrData[0])) | strobe.setOvf;
      edgeFlag <= (edgeFlag & ~(strobe.wrStatus & wrData[1])) | strobe.setEdge;
    end
  end

  assign cntAtMax = &countQ;
  assign irq = (ovfFlag & ctrlQ.ovfIrqEn) | (edgeFlag & ctrlQ.edgeIrqEn);

  always_comb begin
    case (regSel)
      SEL_CTRL:   rdData = {{(CNT_W-CTRL_W){1'b0}}, ctrlQ};
      SEL_COUNT:  rdData = countQ;
      SEL_STATUS: rdData = {{(CNT_W-2){1'b0}}, edgeFlag, ovfFlag};
      default:    rdData = '0;
    endcase
  end

  assert_load_wins_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> countQ == $past(wrData));

  assert_inc_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.inc |=> countQ == CNT_W'($past(countQ) + 1'b1));

  assert_ovf_sticks_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setOvf |=> ovfFlag);

  assert_wrap_sets_ovf_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inc && cntAtMax) |=> (countQ == '0) && ovfFlag);

  assert_clear_ovf_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrStatus && wrData[0] && !strobe.setOvf) |=> !ovfFlag);

  assert_disabled_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ.enable && !strobe.load) |=> $stable(countQ));

endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
  import pulse_accum_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             pinIn,
  input  logic [1:0]       regSel,
  input  logic             regWr,
  input  logic [CNT_W-1:0] regWrData,
  output logic [CNT_W-1:0] regRdData,
  output logic             irq
);

  paStrobe_t strobe;
  paCtrl_t   ctrlQ;
  logic      syncLevel;
  logic      riseSeen;
  logic      fallSeen;
  logic      cntAtMax;

  pa_input_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .syncLevel (syncLevel),
    .riseSeen  (riseSeen),
    .fallSeen  (fallSeen)
  );

  pa_control u_ctrl (
    .ctrl      (ctrlQ),
    .regWr     (regWr),
    .regSel    (regSel),
    .syncLevel (syncLevel),
    .riseSeen  (riseSeen),
    .fallSeen  (fallSeen),
    .tickEn    (tickEn),
    .cntAtMax  (cntAtMax),
    .strobe    (strobe)
  );

  pa_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (regWrData),
    .regSel   (regSel),
    .ctrlQ    (ctrlQ),
    .cntAtMax (cntAtMax),
    .rdData   (regRdData),
    .irq      (irq)
  );

  // gated mode holds the counter when no tick arrives
  assert_gated_needs_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ.gated && !tickEn && !strobe.load) |=> $stable(u_dp.countQ));

  // edge mode never counts without a detected edge
  assert_event_needs_edge_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ.gated && !riseSeen && !fallSeen && !strobe.load) |=> $stable(u_dp.countQ));

endmodule

// File: tb/pulse_accum_bench.sv
module pulse_accum_bench;

  localparam logic [1:0] S_CTRL = 2'd0, S_CNT = 2'd1, S_STAT = 2'd2, S_NONE = 2'd3;
  localparam logic [7:0] C_EN = 8'h01, C_GATE = 8'h02, C_POL = 8'h04,
                         C_OVFIE = 8'h08, C_EDGIE = 8'h10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic pinIn = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic regWr = 1'b0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pulse_accum u_pulse_accum (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .pinIn(pinIn),
    .regSel(regSel), .regWr(regWr), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    regSel = sel; regWrData = data; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] v);
    regSel = sel;
    #1;
    v = regRdData;
  endtask

  task automatic pulse();
    @(negedge clk); pinIn = 1'b1;
    repeat (4) @(negedge clk);
    pinIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic test_reset();
    logic [7:0] v;
    rd(S_CTRL, v); chk("R1 ctrl", v, 8'h00);
    rd(S_CNT, v);  chk("R1 count", v, 8'h00);
    rd(S_STAT, v); chk("R1 status", v, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic test_regs();
    logic [7:0] v;
    wr(S_CNT, 8'hA5);
    rd(S_CNT, v); chk("R2 count readback", v, 8'hA5);
    wr(S_NONE, 8'hFF);
    rd(S_NONE, v); chk("R2 unused select", v, 8'h00);
    rd(S_CNT, v); chk("R2 unused write ignored", v, 8'hA5);
  endtask

  task automatic test_event_rise();
    logic [7:0] v;
    wr(S_CTRL, C_EN);
    wr(S_CNT, 8'h00);
    wr(S_STAT, 8'h03);
    @(negedge clk); pinIn = 1'b1;
    @(negedge clk);
    @(negedge clk); rd(S_CNT, v); chk("R3 not yet counted", v, 8'h00);
    @(negedge clk); rd(S_CNT, v); chk("R3 third clock latency", v, 8'h01);
    repeat (2) @(negedge clk);
    pinIn = 1'b0;
    repeat (4) @(negedge clk);
    rd(S_CNT, v); chk("R3 falling edge ignored", v, 8'h01);
    pulse(); pulse();
    rd(S_CNT, v); chk("R3 rising count", v, 8'h03);
    rd(S_STAT, v); chk("R6 edge flag in event mode", v & 8'h02, 8'h02);
  endtask

  task automatic test_event_fall();
    logic [7:0] v;
    wr(S_CTRL, C_EN | C_POL);
    wr(S_CNT, 8'h00);
    pulse(); pulse();
    rd(S_CNT, v); chk("R3 falling count", v, 8'h02);
  endtask

  task automatic test_tick_ignored();
    logic [7:0] v;
    wr(S_CTRL, C_EN);
    wr(S_CNT, 8'h00);
    @(negedge clk); tickEn = 1'b1;
    repeat (6) @(negedge clk);
    tickEn = 1'b0;
    rd(S_CNT, v); chk("R10 ticks add nothing", v, 8'h00);
    pulse();
    rd(S_CNT, v); chk("R10 edge counts without tick", v, 8'h01);
  endtask

  task automatic test_gated_high();
    logic [7:0] v;
    wr(S_CTRL, C_EN | C_GATE);
    wr(S_CNT, 8'h00);
    wr(S_STAT, 8'h03);
    @(negedge clk); pinIn = 1'b1;
    repeat (5) @(negedge clk);
    rd(S_CNT, v); chk("R4 no tick no count", v, 8'h00);
    rd(S_STAT, v); chk("R6 leading edge leaves flag", v, 8'h00);
    tickEn = 1'b1;
    repeat (6) @(negedge clk);
    tickEn = 1'b0;
    rd(S_CNT, v); chk("R4 six ticks", v, 8'h06);
    pinIn = 1'b0;
    repeat (4) @(negedge clk);
    rd(S_STAT, v); chk("R6 trailing edge sets flag", v, 8'h02);
    tickEn = 1'b1;
    repeat (4) @(negedge clk);
    tickEn = 1'b0;
    rd(S_CNT, v); chk("R4 gate inactive holds", v, 8'h06);
  endtask

  task automatic test_gated_low();
    logic [7:0] v;
    wr(S_CTRL, C_EN | C_GATE | C_POL);
    wr(S_CNT, 8'h00);
    @(negedge clk); tickEn = 1'b1;
    repeat (3) @(negedge clk);
    tickEn = 1'b0;
    rd(S_CNT, v); chk("R4 active low gate", v, 8'h03);
    wr(S_STAT, 8'h03);
    @(negedge clk); pinIn = 1'b1;
    repeat (4) @(negedge clk);
    rd(S_STAT, v); chk("R6 trailing rise for active low", v, 8'h02);
    pinIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic test_overflow_irq();
    logic [7:0] v;
    wr(S_CTRL, C_EN);
    wr(S_STAT, 8'h03);
    wr(S_CNT, 8'hFE);
    pulse();
    rd(S_STAT, v); chk("R5 no overflow at FF", v & 8'h01, 8'h00);
    pulse();
    rd(S_CNT, v); chk("R5 wrap to zero", v, 8'h00);
    rd(S_STAT, v); chk("R5 overflow flag", v & 8'h01, 8'h01);
    chk("R8 irq masked", {7'd0, irq}, 8'h00);
    wr(S_CTRL, C_EN | C_OVFIE);
    chk("R8 overflow irq", {7'd0, irq}, 8'h01);
    wr(S_STAT, 8'h01);
    rd(S_STAT, v); chk("R7 clear only overflow", v, 8'h02);
    chk("R8 irq drops", {7'd0, irq}, 8'h00);
    wr(S_CTRL, C_EN | C_EDGIE);
    chk("R8 edge irq", {7'd0, irq}, 8'h01);
    wr(S_STAT, 8'h02);
    chk("R7 edge cleared irq low", {7'd0, irq}, 8'h00);
  endtask

  task automatic test_priority();
    logic [7:0] v;
    wr(S_CTRL, C_EN | C_GATE);
    @(negedge clk); pinIn = 1'b1;
    repeat (4) @(negedge clk);
    wr(S_CNT, 8'hFF);
    wr(S_STAT, 8'h03);
    @(negedge clk);
    tickEn = 1'b1; regSel = S_CNT; regWrData = 8'h20; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
    rd(S_CNT, v); chk("R2 write beats count", v, 8'h20);
    rd(S_STAT, v); chk("R2 no overflow on write", v & 8'h01, 8'h00);
    @(negedge clk);
    rd(S_CNT, v); chk("R4 count resumes", v, 8'h21);
    tickEn = 1'b0;
    wr(S_CNT, 8'hFF);
    @(negedge clk); tickEn = 1'b1;
    @(negedge clk); tickEn = 1'b0;
    rd(S_STAT, v); chk("R5 gated overflow", v & 8'h01, 8'h01);
    wr(S_CNT, 8'hFF);
    @(negedge clk);
    tickEn = 1'b1; regSel = S_STAT; regWrData = 8'h01; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0; tickEn = 1'b0;
    rd(S_STAT, v); chk("R7 set beats clear", v & 8'h01, 8'h01);
    rd(S_CNT, v); chk("R5 wrapped with clear", v, 8'h00);
    pinIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic test_disabled();
    logic [7:0] v;
    wr(S_CTRL, 8'h00);
    wr(S_STAT, 8'h03);
    wr(S_CNT, 8'h33);
    pulse(); pulse();
    @(negedge clk); tickEn = 1'b1;
    repeat (4) @(negedge clk);
    tickEn = 1'b0;
    rd(S_CNT, v); chk("R9 disabled count holds", v, 8'h33);
    rd(S_STAT, v); chk("R9 disabled flags hold", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_regs();
    test_event_rise();
    test_event_fall();
    test_tick_ignored();
    test_gated_high();
    test_gated_low();
    test_overflow_irq();
    test_priority();
    test_disabled();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule